// File: doc/BRIEF.md
# Printer Port Register Interface

This block is the host-side register file of a byte-wide printer port. A simple synchronous bus reaches three registers: an output/input data register, a status register and a control register. A level interrupt goes to the host. The block contains a local printer model. A strobe edge written through the control register hands the latched output byte to a one-byte output stream and drops the not-busy status bit. After that, each status read steps the acknowledge and not-busy bits through the handshake that a printer would drive.

An external source can load the input data latch at any time. Software reads the input latch through the data offset when the direction bit is set. Each bus access takes one cycle. Read data is combinational during the read cycle, and all side effects take place at the clock edge that ends that cycle.

The output stream follows valid/ready rules. A byte is offered with `pbyte_valid` and stays stable until the cycle in which `pbyte_ready` is high, which consumes it. When `pbyte_ready` is tied high, each emitted byte appears as a one-cycle pulse. The emitter never stalls the bus. A strobe emission that arrives while an earlier byte is still held and not accepted is discarded.

Top module: `prn_port_regs`

## Requirements
- R1: After reset, the data read returns 0xFF, status reads 0xD9, control reads 0xCC, and `irq` and `pbyte_valid` are low.
- R2: The address selects data (0), status (1) or control (2). Reads of offsets 3 to 7 return 0xFF. Writes to status (offset 1) and to offsets 3 to 7 change no register.
- R3: A control write stores the written byte with bits 7 and 6 forced to 1, and reading control returns that stored value.
- R4: A control write with bit 2 (init) at 0 loads status with 0xD8.
- R5: A control write with init (bit 2), select (bit 3) and strobe (bit 0) all at 1 clears status bit 7 (not-busy). If the stored strobe bit was 0 before that write, the output data latch is emitted as one stream byte.
- R6: A control write with init=1, select=1 and strobe=0 sets the interrupt-pending flag, but only if bit 4 (interrupt enable) of the control value stored before the write is 1.
- R7: A data write loads the output latch. A data read returns the input latch when control bit 5 (direction) is 1, and the output latch otherwise.
- R8: A status read returns the current status and clears the pending flag. Then, if not-busy (bit 7) and the stored strobe are both 0, the read steps the handshake. If acknowledge (bit 6) is 1, it is cleared. Otherwise both bit 6 and bit 7 are set.
- R9: `irq` is a register. At the clock edge that follows every cycle containing an access, it takes the pending flag's value.
- R10: A cycle with `in_load` high loads `in_data` into the input latch.
- R11: While `pbyte_valid` is high and `pbyte_ready` is low, `pbyte_valid` and `pbyte_data` hold. A held byte leaves at the edge of a cycle in which `pbyte_ready` is high. An emission in the same cycle as such an edge replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access in this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle |
| in_load | input | 1 | Load the input latch |
| in_data | input | 8 | Byte for the input latch |
| pbyte_valid | output | 1 | Emitted byte is offered |
| pbyte_ready | input | 1 | Consumer takes the offered byte |
| pbyte_data | output | 8 | Emitted byte |
| irq | output | 1 | Interrupt level |

## Verification
Read data is due in the access cycle itself. The bench samples it one nanosecond after the falling edge, before the rising edge that applies the side effects. Status steps, latch loads and stream bytes become visible one edge after the access. `irq` reflects the pending flag one edge later still. The bench updates its arithmetic model of the port at each rising edge and compares the outputs one nanosecond after that edge. It first updates the irq expectation from the pending value held before the edge, and only then applies the access effects, so the extra stage is counted correctly.

// File: rtl/prn_port_pkg.sv
`timescale 1ns/1ps
package prn_port_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 3;

  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_STAT = 3'd1;
  localparam logic [OFS_W-1:0] OFS_CTRL = 3'd2;

  // status bit positions
  localparam int ST_NBUSY  = 7;
  localparam int ST_ACK    = 6;
  localparam int ST_PAPER  = 5;
  localparam int ST_ONLINE = 4;
  localparam int ST_NERR   = 3;
  localparam int ST_TMO    = 0;

  // control bit positions
  localparam int CT_DIR  = 5;
  localparam int CT_IEN  = 4;
  localparam int CT_SEL  = 3;
  localparam int CT_INIT = 2;
  localparam int CT_ALF  = 1;
  localparam int CT_STB  = 0;

  localparam logic [BYTE_W-1:0] DATA_RST    = 8'hFF;
  localparam logic [BYTE_W-1:0] STATUS_RST  = 8'hD9;
  localparam logic [BYTE_W-1:0] STATUS_INIT = 8'hD8;
  localparam logic [BYTE_W-1:0] CTRL_RST    = 8'hCC;
  localparam logic [BYTE_W-1:0] CTRL_FORCE  = 8'hC0;
  localparam logic [BYTE_W-1:0] RD_UNMAPPED = 8'hFF;

  typedef struct packed {
    logic wr_data;
    logic wr_ctrl;
    logic rd_stat;
    logic rd_en;
  } acc_t;
endpackage

// File: rtl/prn_decode.sv
`timescale 1ns/1ps
module prn_decode
  import prn_port_pkg::*;
(
  input  logic             sel,
  input  logic             we,
  input  logic [OFS_W-1:0] ofs,
  output acc_t             acc
);
  always_comb begin
    acc         = '0;
    acc.rd_en   = sel && !we;
    acc.wr_data = sel && we && (ofs == OFS_DATA);
    acc.wr_ctrl = sel && we && (ofs == OFS_CTRL);
    acc.rd_stat = sel && !we && (ofs == OFS_STAT);
  end
endmodule

// File: rtl/prn_ctrl_reg.sv
`timescale 1ns/1ps
module prn_ctrl_reg
  import prn_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic              ev_init,
  output logic              ev_busy_clr,
  output logic              ev_emit,
  output logic              ev_pend
);
  logic [BYTE_W-1:0] val;
  logic              armed;

  assign val = wdata | CTRL_FORCE;

  always_comb begin
    armed       = wr_ctrl && val[CT_INIT] && val[CT_SEL];
    ev_init     = wr_ctrl && !val[CT_INIT];
    ev_busy_clr = armed && val[CT_STB];
    ev_emit     = armed && val[CT_STB] && !ctrl_q[CT_STB];
    ev_pend     = armed && !val[CT_STB] && ctrl_q[CT_IEN];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (wr_ctrl) ctrl_q <= val;
  end

  p_ctrl_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_q[7:6] == 2'b11) && (ctrl_q[5:0] == $past(wdata[5:0])));
  p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q));
endmodule

// File: rtl/prn_status_hs.sv
`timescale 1ns/1ps
module prn_status_hs
  import prn_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_init,
  input  logic              ev_busy_clr,
  input  logic              rd_stat,
  input  logic              ctrl_stb,
  output logic [BYTE_W-1:0] status_q
);
  logic step;
  assign step = rd_stat && !status_q[ST_NBUSY] && !ctrl_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= STATUS_RST;
    end else if (ev_init) begin
      status_q <= STATUS_INIT;
    end else if (ev_busy_clr) begin
      status_q[ST_NBUSY] <= 1'b0;
    end else if (step) begin
      if (status_q[ST_ACK]) begin
        status_q[ST_ACK] <= 1'b0;
      end else begin
        status_q[ST_ACK]   <= 1'b1;
        status_q[ST_NBUSY] <= 1'b1;
      end
    end
  end

  p_init_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_init |=> status_q == STATUS_INIT);
  p_busy_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busy_clr |=> !status_q[ST_NBUSY]);
  p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !ctrl_stb && !status_q[ST_NBUSY] && status_q[ST_ACK])
      |=> !status_q[ST_ACK] && !status_q[ST_NBUSY]);
  p_ack_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !ctrl_stb && !status_q[ST_NBUSY] && !status_q[ST_ACK])
      |=> status_q[ST_ACK] && status_q[ST_NBUSY]);
endmodule

// File: rtl/prn_irq_gen.sv
`timescale 1ns/1ps
module prn_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic access,
  input  logic pend_set,
  input  logic pend_clr,
  output logic irq
);
  logic pend_q;
  logic acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      acc_q  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      acc_q <= access;
      if (pend_clr)      pend_q <= 1'b0;
      else if (pend_set) pend_q <= 1'b1;
      if (acc_q) irq <= pend_q;
    end
  end

  p_pend_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |=> !pend_q);
  p_pend_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_set && !pend_clr) |=> pend_q);
  p_irq_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |=> irq == $past(pend_q));
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_q |=> $stable(irq));
endmodule

// File: rtl/prn_out_stream.sv
`timescale 1ns/1ps
module prn_out_stream
  import prn_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_data,
  input  logic              ready,
  output logic              valid,
  output logic [BYTE_W-1:0] data
);
  logic stalled;
  assign stalled = valid && !ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (push && !stalled) begin
      valid <= 1'b1;
      data  <= push_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> valid && $stable(data));
  p_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !stalled) |=> valid && (data == $past(push_data)));
endmodule

// File: rtl/prn_port_regs.sv
`timescale 1ns/1ps
module prn_port_regs
  import prn_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              in_load,
  input  logic [BYTE_W-1:0] in_data,
  output logic              pbyte_valid,
  input  logic              pbyte_ready,
  output logic [BYTE_W-1:0] pbyte_data,
  output logic              irq
);
  acc_t              acc;
  logic [BYTE_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] status_q;
  logic [BYTE_W-1:0] dataw_q;
  logic [BYTE_W-1:0] datar_q;
  logic              ev_init, ev_busy_clr, ev_emit, ev_pend;

  prn_decode u_dec (
    .sel (bus_sel), .we (bus_we), .ofs (bus_addr), .acc (acc)
  );

  prn_ctrl_reg u_ctrl (
    .clk (clk), .rst_n (rst_n), .wr_ctrl (acc.wr_ctrl), .wdata (bus_wdata),
    .ctrl_q (ctrl_q), .ev_init (ev_init), .ev_busy_clr (ev_busy_clr),
    .ev_emit (ev_emit), .ev_pend (ev_pend)
  );

  prn_status_hs u_stat (
    .clk (clk), .rst_n (rst_n), .ev_init (ev_init), .ev_busy_clr (ev_busy_clr),
    .rd_stat (acc.rd_stat), .ctrl_stb (ctrl_q[CT_STB]), .status_q (status_q)
  );

  prn_irq_gen u_irq (
    .clk (clk), .rst_n (rst_n), .access (bus_sel),
    .pend_set (ev_pend), .pend_clr (acc.rd_stat), .irq (irq)
  );

  prn_out_stream u_out (
    .clk (clk), .rst_n (rst_n), .push (ev_emit), .push_data (dataw_q),
    .ready (pbyte_ready), .valid (pbyte_valid), .data (pbyte_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataw_q <= DATA_RST;
      datar_q <= DATA_RST;
    end else begin
      if (acc.wr_data) dataw_q <= bus_wdata;
      if (in_load)     datar_q <= in_data;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (acc.rd_en) begin
      case (bus_addr)
        OFS_DATA: bus_rdata = ctrl_q[CT_DIR] ? datar_q : dataw_q;
        OFS_STAT: bus_rdata = status_q;
        OFS_CTRL: bus_rdata = ctrl_q;
        default:  bus_rdata = RD_UNMAPPED;
      endcase
    end
  end

  p_data_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == OFS_DATA) |=> dataw_q == $past(bus_wdata));
  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_load |=> datar_q == $past(in_data));
  p_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr > OFS_CTRL) |-> bus_rdata == RD_UNMAPPED);
  p_emit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == OFS_CTRL && (bus_wdata[3:0] & 4'b1101) == 4'b1101
     && !ctrl_q[CT_STB] && !(pbyte_valid && !pbyte_ready))
      |=> pbyte_valid && pbyte_data == $past(dataw_q));
endmodule

// File: tb/sim_prn_port_regs.sv
`timescale 1ns/1ps
module sim_prn_port_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, we = 1'b0, in_load = 1'b0, out_ready = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, in_data = '0;
  logic [7:0] rdata, pdata;
  logic       pvalid, irq;

  int checks = 0;
  int fails  = 0;
  logic rdy_g = 1'b1;

  // model state
  logic [7:0] m_dw, m_dr, m_st, m_ct, m_ob;
  logic       m_pend, m_irq, m_ov, m_accq;

  always #2 clk = ~clk;

  prn_port_regs u0 (
    .clk (clk), .rst_n (rst_n), .bus_sel (sel), .bus_we (we), .bus_addr (addr),
    .bus_wdata (wdata), .bus_rdata (rdata), .in_load (in_load), .in_data (in_data),
    .pbyte_valid (pvalid), .pbyte_ready (out_ready), .pbyte_data (pdata), .irq (irq)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [2:0] a);
    case (a)
      3'd0:    return m_ct[5] ? m_dr : m_dw;
      3'd1:    return m_st;
      3'd2:    return m_ct;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic cyc(input logic s, input logic w, input logic [2:0] a, input logic [7:0] d,
                     input logic ld, input logic [7:0] ldd, input string tag);
    logic       e;
    logic [7:0] eb;
    logic [7:0] v;
    @(negedge clk);
    sel = s; we = w; addr = a; wdata = d; in_load = ld; in_data = ldd; out_ready = rdy_g;
    #1;
    if (s && !w) chk(tag, rdata, model_rd(a));
    @(posedge clk);
    #1;
    e = 1'b0; eb = 8'h00;
    if (m_accq) m_irq = m_pend;
    if (ld) m_dr = ldd;
    if (s && w && a == 3'd0) m_dw = d;
    if (s && w && a == 3'd2) begin
      v = d | 8'hC0;
      if (!v[2]) m_st = 8'hD8;
      else if (v[3]) begin
        if (v[0]) begin
          m_st[7] = 1'b0;
          if (!m_ct[0]) begin e = 1'b1; eb = m_dw; end
        end else if (m_ct[4]) m_pend = 1'b1;
      end
      m_ct = v;
    end
    if (s && !w && a == 3'd1) begin
      m_pend = 1'b0;
      if (!m_st[7] && !m_ct[0]) begin
        if (m_st[6]) m_st[6] = 1'b0;
        else begin m_st[6] = 1'b1; m_st[7] = 1'b1; end
      end
    end
    if (e && !(m_ov && !rdy_g)) begin m_ov = 1'b1; m_ob = eb; end
    else if (rdy_g) m_ov = 1'b0;
    m_accq = s;
    chk(tag, {7'd0, irq}, {7'd0, m_irq});
    chk(tag, {7'd0, pvalid}, {7'd0, m_ov});
    if (m_ov) chk(tag, pdata, m_ob);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, 1'b0, 8'h00, tag);
  endtask
  task automatic rd(input logic [2:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 8'h00, 1'b0, 8'h00, tag);
  endtask
  task automatic idle(input string tag);
    cyc(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00, tag);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_dw = 8'hFF; m_dr = 8'hFF; m_st = 8'hD9; m_ct = 8'hCC; m_ob = 8'h00;
    m_pend = 1'b0; m_irq = 1'b0; m_ov = 1'b0; m_accq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    idle("R1");
    rd(3'd0, "R1"); rd(3'd1, "R1"); rd(3'd2, "R1");
    // R2 unmapped offsets and ignored writes
    for (int a = 3; a < 8; a++) rd(a[2:0], "R2");
    wr(3'd1, 8'h00, "R2");
    for (int a = 3; a < 8; a++) wr(a[2:0], 8'h00, "R2");
    rd(3'd0, "R2"); rd(3'd1, "R2"); rd(3'd2, "R2");
    // R7 data latch sweep
    for (int v = 0; v < 256; v++) begin
      wr(3'd0, v[7:0], "R7");
      rd(3'd0, "R7");
    end
    // R10 input latch, R7 direction select
    cyc(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 8'h5A, "R10");
    wr(3'd2, 8'h2C, "R7");
    rd(3'd0, "R10");
    cyc(1'b1, 1'b0, 3'd0, 8'h00, 1'b1, 8'hC3, "R10");
    rd(3'd0, "R10");
    wr(3'd2, 8'h0C, "R7");
    rd(3'd0, "R7");
    // R4 init load
    wr(3'd2, 8'h08, "R4");
    rd(3'd1, "R4");
    // R5/R6/R8/R9 handshake with interrupt
    wr(3'd0, 8'hA5, "R5");
    wr(3'd2, 8'h1C, "R6");
    wr(3'd2, 8'h1D, "R5");
    idle("R11");
    rd(3'd1, "R5");
    wr(3'd2, 8'h1C, "R6");
    idle("R9"); idle("R9");
    rd(3'd1, "R8"); rd(3'd1, "R8"); rd(3'd1, "R8"); rd(3'd1, "R8");
    idle("R9"); idle("R9");
    // R11 back-pressure
    rdy_g = 1'b0;
    wr(3'd0, 8'h3C, "R11");
    wr(3'd2, 8'hDD, "R11");
    wr(3'd2, 8'hDC, "R11");
    wr(3'd0, 8'h77, "R11");
    wr(3'd2, 8'hDD, "R11");
    idle("R11");
    rdy_g = 1'b1;
    idle("R11"); idle("R11");
    // R3 control sweep with varying ready
    for (int v = 0; v < 256; v++) begin
      rdy_g = (v % 3) != 0;
      wr(3'd2, v[7:0], "R3");
      rd(3'd2, "R3");
      rd(3'd1, "R8");
      rd(3'd1, "R8");
      wr(3'd0, v[7:0] ^ 8'hFF, "R7");
    end
    rdy_g = 1'b1;
    idle("R11"); idle("R9"); idle("R9");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule